// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns characters into asynchronous serial frames on a single output line. Software-side logic writes a character of up to 9 bits into a one-entry holding register. When the transmitter is allowed to run, the character moves into a frame shifter, and the holding register is free again for the next character while the current one is still on the line. Each frame is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits.

The line rate comes from an external enable pulse, `tick16`, which runs at sixteen times the bit rate; the divider that makes it lies outside this block. A frame may start only when transmission is enabled, the holding register has a character, the shifter is idle, and, if flow control is switched on, the clear-to-send input is low. A single-cycle interrupt pulse marks one of two events, chosen by configuration: the hand-over from the holding register to the shifter, or the end of the last stop bit.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A frame starts with one low bit on `txd`, followed by the data bits least significant first; `cfg_len` 0 gives 7 data bits (`wr_data[6:0]`), 2 gives 9 bits, and 1 or 3 gives 8 bits. `txd` is high whenever no frame is being sent.
- R2: `cfg_parity` 1 adds an even parity bit (data plus parity has an even count of ones), 2 adds an odd parity bit, and 0 or 3 sends no parity bit. The parity bit follows the last data bit.
- R3: `cfg_two_stop` 0 ends the frame with one high stop bit and 1 ends it with two.
- R4: Every bit of a frame, start bit included, lasts exactly 16 `tick16` pulses. The next bit appears on `txd` one cycle after the 16th pulse.
- R5: A transfer from the holding register to the shifter happens only in a cycle in which `cfg_tx_en` is 1, `buf_empty` is 0 and `tx_idle` is 1. The start bit appears on `txd` in the next cycle.
- R6: With `cfg_cts_gate` 1, no transfer happens while `cts_n` is 1. With `cfg_cts_gate` 0, `cts_n` has no effect.
- R7: `wr_en` loads `wr_data` and clears `buf_empty` in the next cycle. A transfer without a write in the same cycle sets `buf_empty` in the next cycle. A write in the same cycle as a transfer keeps the new character in the holding register.
- R8: With `cfg_irq_sel` 0, `irq` is high for exactly one cycle, in the cycle after each transfer.
- R9: With `cfg_irq_sel` 1, `irq` is high for exactly one cycle, in the cycle after the last stop bit ends.
- R10: Clearing `cfg_tx_en` during a frame lets that frame finish unchanged, and a character waiting in the holding register stays there.
- R11: After synchronous reset, `txd` is 1, `buf_empty` is 1, `tx_idle` is 1 and `irq` is 0.
- R12: Length, parity and stop settings are captured at the transfer. Changing them during a frame does not alter that frame.
- R13: `tx_idle` falls in the cycle after a transfer and rises in the cycle after the last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_len | input | 2 | Data length select (0: 7, 1/3: 8, 2: 9) |
| cfg_parity | input | 2 | Parity select (0/3: none, 1: even, 2: odd) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_cts_gate | input | 1 | 1 makes transfers wait for `cts_n` low |
| cfg_irq_sel | input | 1 | Interrupt event: 0 transfer, 1 frame end |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding register is empty |
| tx_idle | output | 1 | Shifter is not sending a frame |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The assertions check several rules on every cycle. They check that the line is high while the shifter is idle, that a transfer is followed by a low start bit, and that a transfer never meets a busy shifter. They also check that a character stays held while transmission is disabled or clear-to-send blocks it, and that the interrupt is a single-cycle pulse tied to the selected event. Some behaviour only the bench scenarios can show: the exact bit order, the parity values for each length, the stop count, the 16-pulse bit width, and the effect of changing the settings or clearing the enable in the middle of a frame. For these, the bench compares every output on every cycle against a behavioural model built from queues.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

  typedef enum logic [1:0] {
    LEN_SHORT   = 2'd0,
    LEN_MID     = 2'd1,
    LEN_LONG    = 2'd2,
    LEN_MID_ALT = 2'd3
  } len_sel_e;

  typedef enum logic [1:0] {
    PAR_OFF     = 2'd0,
    PAR_EVEN    = 2'd1,
    PAR_ODD     = 2'd2,
    PAR_OFF_ALT = 2'd3
  } par_sel_e;

  typedef struct packed {
    len_sel_e len;
    par_sel_e par;
    logic     two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/txu_holding.sv
module txu_holding #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              cts_gate,
  input  logic              cts_n,
  input  logic              shift_busy,
  output logic              load,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty
);

  logic              empty_q;
  logic [DATA_W-1:0] data_q;

  assign load      = !empty_q && tx_en && !shift_busy && (!cts_gate || !cts_n);
  assign hold_data = data_q;
  assign empty     = empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      data_q  <= '0;
    end else if (wr_en) begin
      data_q  <= wr_data;
      empty_q <= 1'b0;
    end else if (load) begin
      empty_q <= 1'b1;
    end
  end

  // R5: a held character waits while transmission is disabled
  p_hold_while_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (!empty_q && !tx_en) |=> !empty_q);

  // R6: a held character waits while clear-to-send blocks it
  p_hold_while_cts_high_r6: assert property (@(posedge clk) disable iff (rst)
    (!empty_q && cts_gate && cts_n) |=> !empty_q);

  // R7: hand-over without a write frees the register
  p_empty_after_xfer_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_en) |=> empty_q);

  // R7: a write always leaves the register occupied
  p_write_fills_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !empty_q);

endmodule

// File: rtl/txu_framer.sv
module txu_framer
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  frame_cfg_t        cfg,
  output logic              txd,
  output logic              busy,
  output logic              frame_end
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [LEFT_W-1:0]  left_q;
  logic [CNT_W-1:0]   tcnt_q;
  logic               busy_q;
  logic               txd_q;

  logic [FRAME_W-1:0] fr_c;
  int                 len_c;
  int                 nbits_c;
  logic               ones_c;
  logic               has_par_c;
  logic               adv;

  // Assemble the full frame image from the captured settings
  always_comb begin
    case (cfg.len)
      LEN_SHORT: len_c = DATA_W - 2;
      LEN_LONG:  len_c = DATA_W;
      default:   len_c = DATA_W - 1;
    endcase
    ones_c  = 1'b0;
    fr_c    = '1;
    fr_c[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < len_c) begin
        fr_c[1 + i] = ld_data[i];
        ones_c      = ones_c ^ ld_data[i];
      end
    end
    has_par_c = (cfg.par == PAR_EVEN) || (cfg.par == PAR_ODD);
    if (has_par_c) fr_c[1 + len_c] = ones_c ^ (cfg.par == PAR_ODD);
    nbits_c = 2 + len_c + (has_par_c ? 1 : 0) + (cfg.two_stop ? 1 : 0);
  end

  assign adv       = busy_q && tick && (tcnt_q == CNT_W'(OVS - 1));
  assign frame_end = adv && (left_q == '0);
  assign txd       = txd_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load) begin
      sh_q   <= fr_c;
      txd_q  <= fr_c[0];
      left_q <= LEFT_W'(nbits_c - 1);
      tcnt_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (tick) tcnt_q <= (tcnt_q == CNT_W'(OVS - 1)) ? '0 : tcnt_q + 1'b1;
      if (adv) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          txd_q  <= sh_q[1];
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  // R1: a hand-over is followed by a low start bit on a busy shifter
  p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> (!txd_q && busy_q));

  // R1: the line rests high whenever no frame is in flight
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);

  // R5: the holding side never hands over into a busy shifter
  p_no_xfer_when_busy_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy_q);

  // R4: the line holds its level between sampling-tick boundaries
  p_bit_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !adv) |=> $stable(txd_q));

endmodule

// File: rtl/txu_irq.sv
module txu_irq (
  input  logic clk,
  input  logic rst,
  input  logic sel_done,
  input  logic xfer,
  input  logic frame_end,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= sel_done ? frame_end : xfer;
  end

  assign irq = irq_q;

  // R8/R9: the request is a one-cycle pulse
  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R8: hand-over event raises the request next cycle
  p_irq_on_xfer_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel_done && xfer) |=> irq_q);

  // R9: end of last stop bit raises the request next cycle
  p_irq_on_end_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_done && frame_end) |=> irq_q);

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_tx_en,
  input  logic [1:0]        cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              cfg_cts_gate,
  input  logic              cfg_irq_sel,
  input  logic              cts_n,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_idle,
  output logic              irq
);

  frame_cfg_t        cfg;
  logic              xfer;
  logic [DATA_W-1:0] hold_data;
  logic              shift_busy;
  logic              frame_end;

  always_comb begin
    cfg.len      = len_sel_e'(cfg_len);
    cfg.par      = par_sel_e'(cfg_parity);
    cfg.two_stop = cfg_two_stop;
  end

  txu_holding #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .tx_en      (cfg_tx_en),
    .cts_gate   (cfg_cts_gate),
    .cts_n      (cts_n),
    .shift_busy (shift_busy),
    .load       (xfer),
    .hold_data  (hold_data),
    .empty      (buf_empty)
  );

  txu_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .load      (xfer),
    .ld_data   (hold_data),
    .cfg       (cfg),
    .txd       (txd),
    .busy      (shift_busy),
    .frame_end (frame_end)
  );

  txu_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .sel_done  (cfg_irq_sel),
    .xfer      (xfer),
    .frame_end (frame_end),
    .irq       (irq)
  );

  assign tx_idle = !shift_busy;

  // R13: idle flag drops right after a hand-over
  p_idle_falls_r13: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !tx_idle);

endmodule

// File: tb/dbuf_uart_tx_test.sv
module dbuf_uart_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       cfg_tx_en = 1'b0;
  logic [1:0] cfg_len = 2'd1;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_cts_gate = 1'b0;
  logic       cfg_irq_sel = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd, buf_empty, tx_idle, irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  dbuf_uart_tx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_tx_en(cfg_tx_en), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_cts_gate(cfg_cts_gate),
    .cfg_irq_sel(cfg_irq_sel), .cts_n(cts_n), .txd(txd),
    .buf_empty(buf_empty), .tx_idle(tx_idle), .irq(irq)
  );

  // 16x enable: one pulse every third cycle
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   <= (tdiv == 2) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 2);
  end

  // Behavioural reference model
  bit       q[$];
  bit       m_full = 0, m_busy = 0, m_txd = 1, m_irq = 0;
  int       m_tcnt = 0;
  bit [8:0] m_data = '0;

  always @(posedge clk) begin
    bit ld, adv, fend;
    int len;
    bit p;
    if (rst) begin
      q.delete(); m_full = 0; m_busy = 0; m_txd = 1; m_irq = 0; m_tcnt = 0;
    end else begin
      ld   = m_full && cfg_tx_en && !m_busy && (!cfg_cts_gate || !cts_n);
      adv  = m_busy && tick16 && (m_tcnt == 15);
      fend = adv && (q.size() == 0);
      if (ld) begin
        len = (cfg_len == 0) ? 7 : (cfg_len == 2) ? 9 : 8;
        q.delete();
        q.push_back(1'b0);
        p = 1'b0;
        for (int i = 0; i < len; i++) begin q.push_back(m_data[i]); p ^= m_data[i]; end
        if (cfg_parity == 1) q.push_back(p);
        if (cfg_parity == 2) q.push_back(!p);
        q.push_back(1'b1);
        if (cfg_two_stop) q.push_back(1'b1);
        m_txd = q.pop_front(); m_busy = 1; m_tcnt = 0;
      end else if (m_busy) begin
        if (tick16) m_tcnt = (m_tcnt + 1) % 16;
        if (adv) begin
          if (q.size() == 0) begin m_busy = 0; m_txd = 1; end
          else m_txd = q.pop_front();
        end
      end
      if (wr_en) begin m_data = wr_data; m_full = 1; end
      else if (ld) m_full = 0;
      m_irq = cfg_irq_sel ? fend : ld;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, tagged by the running scenario
  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk(txd == m_txd, cur_req, "txd (R1)", txd, m_txd);
      chk(buf_empty == !m_full, cur_req, "buf_empty (R7)", buf_empty, !m_full);
      chk(tx_idle == !m_busy, cur_req, "tx_idle (R13)", tx_idle, !m_busy);
      chk(irq == m_irq, cur_req, cfg_irq_sel ? "irq (R9)" : "irq (R8)", irq, m_irq);
    end
  end

  int irq_seen = 0;
  always @(negedge clk) if (!rst && irq) irq_seen++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [8:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (tx_idle && buf_empty) break;
    end
    cyc(3);
  endtask

  task automatic set_fmt(input logic [1:0] l, input logic [1:0] p, input logic s);
    @(negedge clk); cfg_len = l; cfg_parity = p; cfg_two_stop = s;
  endtask

  task automatic scenarios();
    cyc(4);
    @(negedge clk); rst = 1'b0;
    chk(txd == 1, "R11", "txd after reset", txd, 1);
    chk(buf_empty == 1, "R11", "buf_empty after reset", buf_empty, 1);
    chk(tx_idle == 1, "R11", "tx_idle after reset", tx_idle, 1);
    chk(irq == 0, "R11", "irq after reset", irq, 0);
    run_cmp = 1;
    cfg_tx_en = 1'b1;

    cur_req = "R1";
    set_fmt(2'd1, 2'd0, 1'b0); put(9'h0A5); wait_idle();
    set_fmt(2'd0, 2'd0, 1'b0); put(9'h1C3); wait_idle();
    set_fmt(2'd3, 2'd3, 1'b0); put(9'h03C); wait_idle();

    cur_req = "R2";
    set_fmt(2'd0, 2'd1, 1'b0); put(9'h055); wait_idle();
    set_fmt(2'd2, 2'd2, 1'b0); put(9'h1FF); wait_idle();
    set_fmt(2'd1, 2'd2, 1'b0); put(9'h000); wait_idle();

    cur_req = "R3";
    set_fmt(2'd2, 2'd1, 1'b1); put(9'h12D); wait_idle();

    cur_req = "R4";
    set_fmt(2'd1, 2'd1, 1'b1); put(9'h0F0); wait_idle();

    cur_req = "R13";
    set_fmt(2'd1, 2'd0, 1'b0); put(9'h081); cyc(2);
    chk(tx_idle == 0, "R13", "tx_idle during frame", tx_idle, 0);
    wait_idle();
    chk(tx_idle == 1, "R13", "tx_idle after frame", tx_idle, 1);

    cur_req = "R7";
    put(9'h011); put(9'h022); cyc(2);
    chk(buf_empty == 0, "R7", "second char held while shifting", buf_empty, 0);
    wait_idle();

    cur_req = "R5";
    @(negedge clk); cfg_tx_en = 1'b0;
    put(9'h066); cyc(120);
    chk(buf_empty == 0, "R5", "buf_empty with enable off", buf_empty, 0);
    chk(tx_idle == 1, "R5", "tx_idle with enable off", tx_idle, 1);
    @(negedge clk); cfg_tx_en = 1'b1; wait_idle();

    cur_req = "R6";
    @(negedge clk); cfg_cts_gate = 1'b1; cts_n = 1'b1;
    put(9'h099); cyc(120);
    chk(buf_empty == 0, "R6", "buf_empty while cts high", buf_empty, 0);
    @(negedge clk); cts_n = 1'b0; cyc(3);
    chk(buf_empty == 1, "R6", "transfer after cts low", buf_empty, 1);
    wait_idle();
    @(negedge clk); cfg_cts_gate = 1'b0; cts_n = 1'b1;
    put(9'h0AA); cyc(3);
    chk(buf_empty == 1, "R6", "cts ignored when gating off", buf_empty, 1);
    wait_idle();
    @(negedge clk); cts_n = 1'b0;

    cur_req = "R8";
    @(negedge clk); cfg_irq_sel = 1'b0; irq_seen = 0;
    put(9'h0C3); wait_idle();
    chk(irq_seen == 1, "R8", "pulses per frame on transfer", irq_seen, 1);

    cur_req = "R9";
    @(negedge clk); cfg_irq_sel = 1'b1; irq_seen = 0;
    put(9'h13C); wait_idle();
    chk(irq_seen == 1, "R9", "pulses per frame on frame end", irq_seen, 1);
    @(negedge clk); cfg_irq_sel = 1'b0;

    cur_req = "R10";
    put(9'h0E7); put(9'h07E); cyc(30);
    @(negedge clk); cfg_tx_en = 1'b0;
    chk(tx_idle == 0, "R10", "frame in flight at disable", tx_idle, 0);
    forever begin @(negedge clk); if (tx_idle) break; end
    cyc(100);
    chk(buf_empty == 0, "R10", "next char held after disable", buf_empty, 0);
    chk(txd == 1, "R10", "line idle after disable", txd, 1);
    @(negedge clk); cfg_tx_en = 1'b1; wait_idle();

    cur_req = "R12";
    set_fmt(2'd2, 2'd1, 1'b1); put(9'h1A6); cyc(100);
    set_fmt(2'd0, 2'd0, 1'b0); wait_idle();
    set_fmt(2'd0, 2'd2, 1'b0); put(9'h04B); cyc(60);
    set_fmt(2'd2, 2'd1, 1'b1); wait_idle();
  endtask

  initial begin
    fork
      scenarios();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule